// File: doc/BRIEF.md
# 64-bit Alarm Timer

A free-running 64-bit tick counter with four compare alarms, reached through a simple 32-bit register interface that has a write strobe, a read strobe, a word-aligned address and combinational read data. The counter advances by one on every clock cycle in which `tick_en` is high, unless software has paused it or an enabled debug-halt input is active. The tick pulse is generated outside the block, and the block has no clock-domain crossing.

Software sets the time by writing the low word and then the high word. The low word waits in a buffer until the high-word write, and both halves load into the counter together. For a coherent 64-bit read, software reads the low word first. That read captures the high word, and a later read of the high-word register returns the captured value. Two raw registers return the live count and have no side effects. Each alarm is armed by writing its 32-bit target. It fires when the low word of the counter equals the target, which disarms it and sets its raw interrupt bit. Each interrupt output is the raw bit masked by an enable bit, ORed with a force bit.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset the count, the low-word buffer, the captured high word, every alarm target, armed bit, raw, enable and force bit, and the software pause bit are 0. Both debug-halt enable bits are 1, and `irq` is 0.
- R2: A write to offset 0x04 stores the low word in a buffer and leaves the count unchanged. A write to offset 0x00 loads the count with {written data, buffered low word} on that clock edge.
- R3: On each cycle with `tick_en` high and no hold active, the 64-bit count increases by exactly one, and the carry passes from bit 31 into bit 32. Offset 0x24 returns the live bits 63:32 and offset 0x28 returns the live bits 31:0.
- R4: A read of offset 0x0C returns the live low word and captures the live high word. A read of offset 0x08 returns the captured high word, even after the count has moved on.
- R5: Reads of the raw offsets 0x24 and 0x28 do not change the captured high word.
- R6: Offset 0x30 bit 0 is a software pause. While it is 1 the count holds, and the bit reads back.
- R7: Offset 0x2C bit 1 enables a hold while `dbg_halt[0]` is high, and bit 2 enables a hold while `dbg_halt[1]` is high. A debug input whose enable bit is 0 has no effect. The register reads back with all other bits 0.
- R8: A write to offset 0x10 + 4*i sets the target of alarm i and arms it, and the target reads back at that offset. An armed alarm whose target equals count bits 31:0 fires on the next clock edge, which clears its armed bit and sets its raw interrupt bit. Count bits 63:32 are ignored in the compare.
- R9: Offset 0x20 reads the armed bits, with alarm i in bit i. Writing 1 to bit i disarms alarm i, and writing 0 leaves it unchanged.
- R10: Offset 0x34 reads the raw interrupt bits, with alarm i in bit i. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: Offsets 0x38 (enable) and 0x3C (force) are read/write, one bit per alarm. Offset 0x40 and the `irq` output both equal (raw AND enable) OR force, bit for bit.
- R12: Reads of the write-only offsets 0x00 and 0x04, and of any offset above 0x40, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-advance pulse |
| dbg_halt | input | 2 | Debug-halt indications, one per processor |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed only for the capture side effect) |
| bus_addr | input | 7 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 4 | Per-alarm interrupt after masking and forcing |

## Verification
The bench loads the count just below a 32-bit boundary and checks the carry into the high word. It captures the high word before a carry and reads it after the carry. A design that captured on the wrong read, or returned the live word, would give a high half one count too large. It arms all four alarms at staggered targets while the high word is nonzero and checks the raw bits after every single tick. Firing one cycle early or late, or comparing all 64 bits, shows up as a wrong bit pattern. It also sweeps all 256 enable/force combinations against a fixed raw pattern, and it checks that a disabled debug input and a written 0 in the clear and disarm registers change nothing.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the alarm timer: register word indices (byte offset / 4).
// Assumes a 7-bit byte address with the two low bits ignored.
package tmr_pkg;
    localparam int WORD_W = 5;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t W_TIME_HI_WR = 5'd0;
    localparam word_t W_TIME_LO_WR = 5'd1;
    localparam word_t W_TIME_HI_RD = 5'd2;
    localparam word_t W_TIME_LO_RD = 5'd3;
    localparam word_t W_ALARM0     = 5'd4;
    localparam word_t W_ARMED      = 5'd8;
    localparam word_t W_RAW_HI     = 5'd9;
    localparam word_t W_RAW_LO     = 5'd10;
    localparam word_t W_DBG        = 5'd11;
    localparam word_t W_PAUSE      = 5'd12;
    localparam word_t W_IRQ_RAW    = 5'd13;
    localparam word_t W_IRQ_EN     = 5'd14;
    localparam word_t W_IRQ_FRC    = 5'd15;
    localparam word_t W_IRQ_STAT   = 5'd16;
endpackage

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
// Double-width time counter with a buffered split load.
// Assumes: the low-word write comes before the high-word write; the high-word
// write loads both halves at once and takes priority over counting.
module tmr_count #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            halt,
    input  logic            lo_we,
    input  logic            hi_we,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cnt
);
    localparam int CW = 2 * DW;
    localparam logic [CW-1:0] STEP = CW'(1);

    logic [DW-1:0] lo_buf;

    // Hold the low half until the matching high half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_buf <= '0;
        else if (lo_we) lo_buf <= wdata;
    end

    // Load both halves, or step once per unheld tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (hi_we)             cnt <= {wdata, lo_buf};
        else if (tick_en && !halt)  cnt <= cnt + STEP;
    end

    AST_LOAD_BOTH_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> cnt == {$past(wdata), $past(lo_buf)}); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_we && tick_en && !halt) |=> cnt == $past(cnt) + STEP); // R3
    AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_we && halt) |=> $stable(cnt)); // R6
endmodule

// File: rtl/tmr_alarm.sv
`timescale 1ns/1ps
// Bank of compare alarms against the low half of the count.
// Assumes: writing a target arms the alarm and wins over a same-cycle match or
// disarm; a match on an armed alarm fires for one cycle and disarms it.
module tmr_alarm #(
    parameter int DW = 32,
    parameter int N  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       cnt_lo,
    input  logic [N-1:0]        arm_we,
    input  logic [N-1:0]        disarm,
    input  logic [DW-1:0]       wdata,
    output logic [N-1:0][DW-1:0] target,
    output logic [N-1:0]        armed,
    output logic [N-1:0]        fire
);
    for (genvar i = 0; i < N; i++) begin : g_alarm
        // Fire pulse: armed, matching, and not being rewritten.
        assign fire[i] = armed[i] && (cnt_lo == target[i]) && !arm_we[i];

        // Target and armed state of one alarm.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                target[i] <= '0;
                armed[i]  <= 1'b0;
            end else if (arm_we[i]) begin
                target[i] <= wdata;
                armed[i]  <= 1'b1;
            end else if (disarm[i] || fire[i]) begin
                armed[i]  <= 1'b0;
            end
        end

        AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            arm_we[i] |=> armed[i] && target[i] == $past(wdata)); // R8
        AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> !armed[i]); // R8
        AST_DISARM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (disarm[i] && !arm_we[i]) |=> !armed[i]); // R9
    end
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
// Per-alarm raw, enable and force bits and the combined interrupt status.
// Assumes: a fire event in the same cycle as a write-1 clear leaves the bit set.
module tmr_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic         frc_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw,
    output logic [N-1:0] en,
    output logic [N-1:0] frc,
    output logic [N-1:0] status
);
    logic [N-1:0] clr_mask;

    // Bits being cleared by software this cycle.
    assign clr_mask = clr_we ? wdata : '0;

    // Raw bits: set by firing, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_mask) | fire;
    end

    // Enable and force registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= '0;
            frc <= '0;
        end else begin
            if (en_we)  en  <= wdata;
            if (frc_we) frc <= wdata;
        end
    end

    // Masked raw merged with forced bits.
    assign status = (raw & en) | frc;

    AST_FIRE_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> (raw & $past(fire)) == $past(fire)); // R10
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && |(wdata & ~fire)) |=> (raw & $past(wdata & ~fire)) == '0); // R10
endmodule

// File: rtl/tick_alarm_timer.sv
`timescale 1ns/1ps
// Top of the 64-bit alarm timer: register decode, read mux, coherent-read
// capture and hold logic around the counter, alarm bank and interrupt block.
// Assumes: N <= 4 (the alarm words sit between the time words and the armed
// word); read data is combinational from the address; bus_rd is used only
// for the capture side effect of the low-word read.
module tick_alarm_timer #(
    parameter int DW = 32,
    parameter int N  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic [1:0]               dbg_halt,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [tmr_pkg::WORD_W+1:0] bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    output logic [N-1:0]             irq
);
    import tmr_pkg::*;

    localparam int CW = 2 * DW;

    word_t                word;
    logic                 unused_addr;
    logic [CW-1:0]        cnt;
    logic [DW-1:0]        hi_latch;
    logic [1:0]           dbg_en;
    logic                 sw_pause;
    logic                 halt;
    logic [N-1:0]         arm_we;
    logic [N-1:0]         disarm;
    logic [N-1:0][DW-1:0] target;
    logic [N-1:0]         armed;
    logic [N-1:0]         fire;
    logic [N-1:0]         raw;
    logic [N-1:0]         en;
    logic [N-1:0]         frc;
    logic [N-1:0]         status;
    logic                 lo_rd;

    // Word index; byte lanes are ignored.
    assign word        = bus_addr[WORD_W+1:2];
    assign unused_addr = ^bus_addr[1:0];
    assign lo_rd       = bus_rd && (word == W_TIME_LO_RD);

    // Counter is held by software pause or an enabled debug halt.
    assign halt = sw_pause || |(dbg_en & dbg_halt);

    // Per-alarm arm strobes and write-one disarm mask.
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign arm_we[i] = bus_wr && (word == word_t'(W_ALARM0 + i));
    end
    assign disarm = (bus_wr && word == W_ARMED) ? bus_wdata[N-1:0] : '0;

    // Control registers: software pause and debug-halt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pause <= 1'b0;
            dbg_en   <= 2'b11;
        end else if (bus_wr) begin
            if (word == W_PAUSE) sw_pause <= bus_wdata[0];
            if (word == W_DBG)   dbg_en   <= bus_wdata[2:1];
        end
    end

    // Capture the high word when the low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_latch <= '0;
        else if (lo_rd) hi_latch <= cnt[CW-1:DW];
    end

    tmr_count #(.DW(DW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .halt    (halt),
        .lo_we   (bus_wr && word == W_TIME_LO_WR),
        .hi_we   (bus_wr && word == W_TIME_HI_WR),
        .wdata   (bus_wdata),
        .cnt     (cnt)
    );

    tmr_alarm #(.DW(DW), .N(N)) u_alarm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_lo (cnt[DW-1:0]),
        .arm_we (arm_we),
        .disarm (disarm),
        .wdata  (bus_wdata),
        .target (target),
        .armed  (armed),
        .fire   (fire)
    );

    tmr_irq #(.N(N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .clr_we (bus_wr && word == W_IRQ_RAW),
        .en_we  (bus_wr && word == W_IRQ_EN),
        .frc_we (bus_wr && word == W_IRQ_FRC),
        .wdata  (bus_wdata[N-1:0]),
        .raw    (raw),
        .en     (en),
        .frc    (frc),
        .status (status)
    );

    assign irq = status;

    // Read mux: every unmapped or write-only word returns zero.
    always_comb begin
        bus_rdata = '0;
        case (word)
            W_TIME_HI_RD:         bus_rdata = hi_latch;
            W_TIME_LO_RD,
            W_RAW_LO:             bus_rdata = cnt[DW-1:0];
            W_RAW_HI:             bus_rdata = cnt[CW-1:DW];
            W_ARMED:              bus_rdata[N-1:0] = armed;
            W_DBG:                bus_rdata[2:1] = dbg_en;
            W_PAUSE:              bus_rdata[0] = sw_pause;
            W_IRQ_RAW:            bus_rdata[N-1:0] = raw;
            W_IRQ_EN:             bus_rdata[N-1:0] = en;
            W_IRQ_FRC:            bus_rdata[N-1:0] = frc;
            W_IRQ_STAT:           bus_rdata[N-1:0] = status;
            default:              bus_rdata = '0;
        endcase
        for (int i = 0; i < N; i++) begin
            if (word == word_t'(W_ALARM0 + i)) bus_rdata = target[i];
        end
    end

    AST_LATCH_ONLY_ON_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_rd |=> $stable(hi_latch)); // R5
    AST_LATCH_TAKES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> hi_latch == $past(cnt[CW-1:DW])); // R4
    AST_DBG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dbg_en & dbg_halt) && !(bus_wr && word == W_TIME_HI_WR)) |=> $stable(cnt)); // R7
endmodule

// File: tb/sim_tick_alarm_timer.sv
`timescale 1ns/1ps
// Self-checking bench for tick_alarm_timer.
module sim_tick_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  dbg_halt = 2'b00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [63:0] cnt_model;

    tick_alarm_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic chk_time(input string req);
        rd_chk(req, 7'h24, cnt_model[63:32]);
        rd_chk(req, 7'h28, cnt_model[31:0]);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 raw hi", 7'h24, 32'h0);
        rd_chk("R1 raw lo", 7'h28, 32'h0);
        rd_chk("R1 latched hi", 7'h08, 32'h0);
        rd_chk("R1 armed", 7'h20, 32'h0);
        rd_chk("R1 dbg enables", 7'h2C, 32'h6);
        rd_chk("R1 pause", 7'h30, 32'h0);
        rd_chk("R1 raw irq", 7'h34, 32'h0);
        rd_chk("R1 alarm target", 7'h1C, 32'h0);
        check("R1 irq pins", {28'h0, irq}, 32'h0);

        // R2: buffered low write, joint load on high write
        wr(7'h04, 32'hFFFF_FFFE);
        rd_chk("R2 low buffered only", 7'h28, 32'h0);
        wr(7'h00, 32'h0000_0005);
        cnt_model = 64'h0000_0005_FFFF_FFFE;
        chk_time("R2 loaded");

        // R3: counting with carry into high word
        tick(3);
        cnt_model += 3;
        chk_time("R3 carry");
        check("R3 model", cnt_model[31:0], 32'h1);

        // R4 / R5: coherent capture across a carry
        wr(7'h04, 32'hFFFF_FFFF);
        wr(7'h00, 32'h0000_0007);
        cnt_model = 64'h0000_0007_FFFF_FFFF;
        rd_chk("R4 low read", 7'h0C, 32'hFFFF_FFFF);
        tick(1);
        cnt_model += 1;
        rd_chk("R4 captured hi", 7'h08, 32'h7);
        rd_chk("R5 raw hi live", 7'h24, 32'h8);
        rd_chk("R5 raw lo live", 7'h28, 32'h0);
        rd_chk("R5 capture untouched", 7'h08, 32'h7);
        rd_chk("R4 low read again", 7'h0C, 32'h0);
        rd_chk("R4 new capture", 7'h08, 32'h8);
        rd_chk("R12 wr-only hi", 7'h00, 32'h0);
        rd_chk("R12 wr-only lo", 7'h04, 32'h0);
        rd_chk("R12 unmapped", 7'h44, 32'h0);
        rd_chk("R12 top", 7'h7C, 32'h0);

        // R6: software pause
        wr(7'h30, 32'h1);
        rd_chk("R6 pause reads", 7'h30, 32'h1);
        tick(5);
        chk_time("R6 held");
        wr(7'h30, 32'h0);
        tick(2);
        cnt_model += 2;
        chk_time("R6 resumed");

        // R7: debug holds
        dbg_halt = 2'b01;
        tick(3);
        chk_time("R7 dbg0 holds");
        wr(7'h2C, 32'h4);
        rd_chk("R7 dbg reg", 7'h2C, 32'h4);
        tick(2);
        cnt_model += 2;
        chk_time("R7 dbg0 disabled");
        dbg_halt = 2'b10;
        tick(2);
        chk_time("R7 dbg1 holds");
        dbg_halt = 2'b00;
        wr(7'h2C, 32'h6);

        // R8: alarm fires on low-word match, high word nonzero
        wr(7'h04, 32'h0);
        wr(7'h00, 32'h3);
        cnt_model = 64'h3_0000_0000;
        wr(7'h10, 32'd10);
        rd_chk("R8 target reads", 7'h10, 32'd10);
        rd_chk("R8 armed", 7'h20, 32'h1);
        tick(9);
        cnt_model += 9;
        rd_chk("R8 not yet", 7'h34, 32'h0);
        tick(1);
        cnt_model += 1;
        rd_chk("R8 disarmed by fire", 7'h20, 32'h0);
        rd_chk("R8 raw set", 7'h34, 32'h1);
        check("R11 masked off", {28'h0, irq}, 32'h0);

        // R9: disarm by write-one
        wr(7'h14, 32'd20);
        wr(7'h20, 32'h0);
        rd_chk("R9 write 0 keeps", 7'h20, 32'h2);
        wr(7'h20, 32'h2);
        rd_chk("R9 write 1 disarms", 7'h20, 32'h0);
        tick(10);
        cnt_model += 10;
        rd_chk("R9 no fire", 7'h34, 32'h1);

        // R10: write-one clear
        wr(7'h34, 32'h0);
        rd_chk("R10 write 0 keeps", 7'h34, 32'h1);
        wr(7'h34, 32'h1);
        rd_chk("R10 cleared", 7'h34, 32'h0);

        // R8 sweep: four alarms at staggered targets, checked every tick
        chk_time("R8 sweep start");
        for (int i = 0; i < 4; i++) wr(7'h10 + 7'(4 * i), 32'd21 + 32'(2 * i));
        rd_chk("R8 all armed", 7'h20, 32'hF);
        for (int s = 0; s < 8; s++) begin
            logic [3:0] e;
            tick(1);
            cnt_model += 1;
            for (int i = 0; i < 4; i++) e[i] = (cnt_model[31:0] >= 32'd21 + 32'(2 * i));
            rd_chk("R8 sweep raw", 7'h34, {28'h0, e});
        end
        rd_chk("R8 sweep armed", 7'h20, 32'h0);
        wr(7'h34, 32'hF);

        // R11: raw = 0101, sweep enable and force
        wr(7'h10, cnt_model[31:0]);
        wr(7'h18, cnt_model[31:0]);
        rd_chk("R11 raw pattern", 7'h34, 32'h5);
        for (int m = 0; m < 16; m++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] ex;
                ex = (4'h5 & 4'(m)) | 4'(f);
                wr(7'h38, 32'(m));
                wr(7'h3C, 32'(f));
                rd(7'h40, v);
                check("R11 status", v, {28'h0, ex});
                check("R11 irq pins", {28'h0, irq}, {28'h0, ex});
            end
        end
        rd_chk("R11 enable reads", 7'h38, 32'hF);
        rd_chk("R11 force reads", 7'h3C, 32'hF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule